// File: doc/BRIEF.md
# Transparent Serial Transmitter with Sync Gating

This block turns a stream of bytes into a serial bit stream for a transparent (bit-synchronous, unframed) channel. It sends one bit per clock. Bytes arrive on a valid/ready stream, and each byte has a flag that marks the final byte of a message. While the block is enabled and has nothing to send, the line stays at the idle level. A message starts only after the selected synchronization source reports that the channel is synchronized. The block can append a 16-bit check sequence and reports the end of every message on a status pulse.

Stream rules: a byte is taken on a clock edge where `s_valid` and `s_ready` are both high. The byte source must hold `s_valid`, `s_data` and `s_last` steady until that edge. `s_ready` never depends on `s_valid`. It is high only in two situations:
- while the block waits at a message start with synchronization present;
- during the final bit of a byte that is not flagged last.

During the rest of a message, and between messages, the block applies back-pressure. Once a message has started, the source has to keep pace with it. If the next byte is missing when it is needed, the message is aborted.

Top module: `tsp_tx`

## Requirements
- R1: While in reset, and while disabled after reset, `txd` is 1, `s_ready` is 0 and `msg_done` is 0.
- R2: After `tx_en` rises, the line sends at least GAP_BITS (default 8) idle ones before the first data bit.
- R3: A message does not start while the selected sync source is low: `s_ready` stays 0 and `txd` stays 1, even with `s_valid` high.
- R4: `sync_sel` = 0 takes the sync from `cts`; `sync_sel` = 1 takes it from `rx_synced`. The unselected source has no effect on starting.
- R5: One cycle after the final bit of a message, `msg_done` pulses high for one cycle with `msg_underrun` = 0, and `txd` returns to 1.
- R6: Between the final bit of one message and the first bit of the next, at least GAP_BITS idle ones are sent, even when the next byte is already waiting.
- R7: Sync is checked again after every message. If the selected source is low once the gap has elapsed, the next message waits until it rises.
- R8: Sync is sampled only at the start of a message. Dropping it mid-message does not alter the bits sent.
- R9: `lsb_first` = 0 sends each byte bit 7 first. `lsb_first` = 1 sends it bit 0 first.
- R10: With `crc_en` = 1, 16 extra bits follow the data. They are the complement of a CRC-16 (polynomial 0x1021, preset 0xFFFF, fed with the data bits in line order), sent from register bit 15 down to bit 0. With `crc_en` = 0, no extra bits are sent.
- R11: If `s_valid` is low when a byte not flagged last finishes, the message ends after that byte. `msg_done` and `msg_underrun` then pulse high together in the next cycle, and the line idles.
- R12: Dropping `tx_en` makes `txd` 1 and `s_ready` 0 in the next cycle. The message in progress is discarded with no `msg_done`.
- R13: `s_ready` is 1 while the block waits at a message start with sync present, whether or not `s_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| sync_sel | input | 1 | Sync source choice: 0 clear-to-send, 1 receiver sync |
| cts | input | 1 | Clear-to-send, active high |
| rx_synced | input | 1 | Receiver synchronized indication |
| crc_en | input | 1 | Append the 16-bit check sequence |
| lsb_first | input | 1 | Bit order within each byte |
| s_valid | input | 1 | Stream byte available |
| s_ready | output | 1 | Stream byte accepted this cycle when valid |
| s_data | input | BYTE_W | Stream byte |
| s_last | input | 1 | Byte is the final one of its message |
| txd | output | 1 | Serial line output, idle high |
| msg_done | output | 1 | One-cycle message completion pulse |
| msg_underrun | output | 1 | Qualifies `msg_done`: message aborted for lack of data |

## Verification
The serializer is driven with these message shapes:
- Single-byte and multi-byte messages, in both bit orders and with the check sequence on and off. Comparing them separates reversed bit order, missing or misplaced check bits, and an off-by-one end-of-message pulse.
- Two messages offered back to back. This shows whether the idle gap is really inserted.
- A message whose sync source drops after the first one. This shows whether sync is checked again.
- A sync drop in mid-message. This shows that sync is sampled only at the start.

The sync inputs are also toggled with data waiting, under each setting of the source select, to confirm that only the chosen source opens the gate. Starving the stream and dropping the enable in mid-message show the two ways a message can end early.

// File: rtl/tsp_pkg.sv
`timescale 1ns/1ps
package tsp_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_GAP  = 3'd1,
    ST_ARM  = 3'd2,
    ST_DATA = 3'd3,
    ST_CRC  = 3'd4
  } tsp_state_e;

  localparam int TSP_CRC_W = 16;
  localparam logic [TSP_CRC_W-1:0] TSP_CRC_POLY = 16'h1021;
  localparam logic [TSP_CRC_W-1:0] TSP_CRC_INIT = 16'hFFFF;
endpackage

// File: rtl/tsp_crc.sv
`timescale 1ns/1ps
// Bit-serial check-sequence register: accumulates line bits, then shifts out inverted.
module tsp_crc #(
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic preset,
  input  logic accum,
  input  logic bit_i,
  input  logic drain,
  output logic out_bit
);
  logic [CRC_W-1:0] reg_q;
  logic             fb;

  assign fb = reg_q[CRC_W-1] ^ bit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= INIT;
    end else if (preset) begin
      reg_q <= INIT;
    end else if (accum) begin
      reg_q <= {reg_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end else if (drain) begin
      reg_q <= {reg_q[CRC_W-2:0], 1'b1};
    end
  end

  assign out_bit = ~reg_q[CRC_W-1];
endmodule

// File: rtl/tsp_shifter.sv
`timescale 1ns/1ps
// Byte shift register; bit order is fixed at load time by reversing the byte.
module tsp_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              lsb_first,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              last_i,
  input  logic              shift,
  output logic              ser_bit,
  output logic              last_q
);
  logic [BYTE_W-1:0] rev;
  logic [BYTE_W-1:0] sh_q;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
    assign rev[i] = data_i[BYTE_W-1-i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      sh_q   <= lsb_first ? rev : data_i;
      last_q <= last_i;
    end else if (shift) begin
      sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign ser_bit = sh_q[BYTE_W-1];
endmodule

// File: rtl/tsp_ctrl.sv
`timescale 1ns/1ps
// Sequencer: off, idle gap, armed (waiting for data and sync), data, check bits.
module tsp_ctrl
  import tsp_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int GAP_BITS = 8,
  parameter int CRC_W    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       sync_ok,
  input  logic       s_valid,
  input  logic       crc_en,
  input  logic       cur_last,
  output tsp_state_e state,
  output logic       s_ready,
  output logic       load,
  output logic       crc_preset,
  output logic       crc_accum,
  output logic       crc_drain,
  output logic       msg_done,
  output logic       msg_underrun
);
  localparam int CNT_MAX0 = (GAP_BITS > BYTE_W) ? GAP_BITS : BYTE_W;
  localparam int CNT_MAX  = (CNT_MAX0 > CRC_W) ? CNT_MAX0 : CRC_W;
  localparam int CNT_W    = (CNT_MAX > 2) ? $clog2(CNT_MAX) : 1;
  localparam logic [CNT_W-1:0] GAP_END  = CNT_W'(GAP_BITS - 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CRC_END  = CNT_W'(CRC_W - 1);

  tsp_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_d, und_d;
  logic             byte_end, hs;

  assign byte_end = (st_q == ST_DATA) && (cnt_q == BYTE_END);
  assign s_ready  = tx_en && (((st_q == ST_ARM) && sync_ok) || (byte_end && !cur_last));
  assign hs       = s_valid && s_ready;
  assign load     = hs;

  assign crc_preset = (st_q == ST_ARM);
  assign crc_accum  = (st_q == ST_DATA);
  assign crc_drain  = (st_q == ST_CRC);
  assign state      = st_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    und_d  = 1'b0;
    unique case (st_q)
      ST_OFF: begin
        st_d  = ST_GAP;
        cnt_d = '0;
      end
      ST_GAP: begin
        if (cnt_q == GAP_END) begin
          st_d  = ST_ARM;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_ARM: begin
        if (hs) begin
          st_d  = ST_DATA;
          cnt_d = '0;
        end
      end
      ST_DATA: begin
        if (!byte_end) begin
          cnt_d = cnt_q + CNT_W'(1);
        end else begin
          cnt_d = '0;
          if (cur_last) begin
            if (crc_en) begin
              st_d = ST_CRC;
            end else begin
              st_d   = ST_GAP;
              done_d = 1'b1;
            end
          end else if (!hs) begin
            st_d   = ST_GAP;
            done_d = 1'b1;
            und_d  = 1'b1;
          end
        end
      end
      ST_CRC: begin
        if (cnt_q == CRC_END) begin
          st_d   = ST_GAP;
          cnt_d  = '0;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        st_d  = ST_OFF;
        cnt_d = '0;
      end
    endcase
    if (!tx_en) begin
      st_d   = ST_OFF;
      cnt_d  = '0;
      done_d = 1'b0;
      und_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_OFF;
      cnt_q        <= '0;
      msg_done     <= 1'b0;
      msg_underrun <= 1'b0;
    end else begin
      st_q         <= st_d;
      cnt_q        <= cnt_d;
      msg_done     <= done_d;
      msg_underrun <= und_d;
    end
  end
endmodule

// File: rtl/tsp_tx.sv
`timescale 1ns/1ps
// Top: sync source select, line multiplexer, wiring of sequencer, shifter and check register.
module tsp_tx
  import tsp_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int GAP_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              sync_sel,
  input  logic              cts,
  input  logic              rx_synced,
  input  logic              crc_en,
  input  logic              lsb_first,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  output logic              txd,
  output logic              msg_done,
  output logic              msg_underrun
);
  tsp_state_e state;
  logic       sync_ok;
  logic       load, cur_last, ser_bit, crc_bit;
  logic       crc_preset, crc_accum, crc_drain;

  assign sync_ok = sync_sel ? rx_synced : cts;

  tsp_ctrl #(
    .BYTE_W  (BYTE_W),
    .GAP_BITS(GAP_BITS),
    .CRC_W   (TSP_CRC_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .sync_ok     (sync_ok),
    .s_valid     (s_valid),
    .crc_en      (crc_en),
    .cur_last    (cur_last),
    .state       (state),
    .s_ready     (s_ready),
    .load        (load),
    .crc_preset  (crc_preset),
    .crc_accum   (crc_accum),
    .crc_drain   (crc_drain),
    .msg_done    (msg_done),
    .msg_underrun(msg_underrun)
  );

  tsp_shifter #(
    .BYTE_W(BYTE_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .lsb_first(lsb_first),
    .data_i   (s_data),
    .last_i   (s_last),
    .shift    (state == ST_DATA),
    .ser_bit  (ser_bit),
    .last_q   (cur_last)
  );

  tsp_crc #(
    .CRC_W(TSP_CRC_W),
    .POLY (TSP_CRC_POLY),
    .INIT (TSP_CRC_INIT)
  ) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .preset (crc_preset),
    .accum  (crc_accum),
    .bit_i  (ser_bit),
    .drain  (crc_drain),
    .out_bit(crc_bit)
  );

  always_comb begin
    unique case (state)
      ST_DATA: txd = ser_bit;
      ST_CRC:  txd = crc_bit;
      default: txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/tsp_tx_chk.sv
`timescale 1ns/1ps
// Port-level protocol checker, attached to every tsp_tx instance.
module tsp_tx_chk #(
  parameter int GAP_BITS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic sync_sel,
  input logic cts,
  input logic rx_synced,
  input logic s_valid,
  input logic s_ready,
  input logic txd,
  input logic msg_done,
  input logic msg_underrun
);
  localparam int ONES_W = $clog2(GAP_BITS + 1) + 1;
  localparam logic [ONES_W-1:0] ONES_SAT = ONES_W'(GAP_BITS);

  logic [ONES_W-1:0] ones_q;
  logic              in_msg_q;
  logic              start;

  assign start = s_valid && s_ready && !in_msg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q   <= '0;
      in_msg_q <= 1'b0;
    end else begin
      if (!txd)                ones_q <= '0;
      else if (ones_q != ONES_SAT) ones_q <= ones_q + ONES_W'(1);
      if (!tx_en)              in_msg_q <= 1'b0;
      else if (start)          in_msg_q <= 1'b1;
      else if (msg_done)       in_msg_q <= 1'b0;
    end
  end

  a_r12_idle_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (txd && !s_ready));

  a_r5_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> txd);

  a_r11_underrun_qualifies_done: assert property (@(posedge clk) disable iff (!rst_n)
    msg_underrun |-> msg_done);

  a_r3_start_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (sync_sel ? rx_synced : cts));

  a_r6_gap_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (ones_q == ONES_SAT));

  a_r5_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> !msg_done);
endmodule

bind tsp_tx tsp_tx_chk #(.GAP_BITS(GAP_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_en       (tx_en),
  .sync_sel    (sync_sel),
  .cts         (cts),
  .rx_synced   (rx_synced),
  .s_valid     (s_valid),
  .s_ready     (s_ready),
  .txd         (txd),
  .msg_done    (msg_done),
  .msg_underrun(msg_underrun)
);

// File: tb/tb_tsp_tx.sv
`timescale 1ns/1ps
module tb_tsp_tx;
  localparam int GAP = 8;
  localparam int LOGN = 4096;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, tx_en = 1'b0, sync_sel = 1'b0, cts = 1'b0, rx_synced = 1'b0;
  logic crc_en = 1'b0, lsb_first = 1'b0, s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_ready, txd, msg_done, msg_underrun;

  tsp_tx #(.BYTE_W(8), .GAP_BITS(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .sync_sel(sync_sel), .cts(cts),
    .rx_synced(rx_synced), .crc_en(crc_en), .lsb_first(lsb_first),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .txd(txd), .msg_done(msg_done), .msg_underrun(msg_underrun)
  );

  int n_chk = 0, n_bad = 0, logn = 0, n_ex = 0;
  bit lg_txd [LOGN], lg_hs [LOGN], lg_done [LOGN], lg_und [LOGN];
  bit ex [512];
  logic [7:0] msg_b [8];
  bit         msg_l [8];

  // line logger, sampled mid-cycle
  always begin
    @(negedge clk);
    #2;
    if (logn < LOGN) begin
      lg_txd[logn]  = (txd === 1'b1);
      lg_hs[logn]   = (s_valid === 1'b1) && (s_ready === 1'b1);
      lg_done[logn] = (msg_done === 1'b1);
      lg_und[logn]  = (msg_underrun === 1'b1);
      logn++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // expected line bits for msg_b[first .. first+n-1]
  function automatic void build(input int first, input int n, input bit lsb, input bit with_crc);
    logic [15:0] c = 16'hFFFF;
    n_ex = 0;
    for (int i = first; i < first + n; i++) begin
      for (int b = 0; b < 8; b++) begin
        bit v = lsb ? msg_b[i][b] : msg_b[i][7-b];
        bit fb = c[15] ^ v;
        ex[n_ex++] = v;
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    if (with_crc) begin
      c = ~c;
      for (int k = 15; k >= 0; k--) ex[n_ex++] = c[k];
    end
  endfunction

  function automatic int find_hs(input int from);
    for (int i = from; i < logn; i++) if (lg_hs[i]) return i;
    return -1;
  endfunction

  task automatic offer(input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      s_data = msg_b[i]; s_last = msg_l[i]; s_valid = 1'b1;
      #1;
      while (s_ready !== 1'b1) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    s_valid = 1'b0;
  endtask

  task automatic hold(input int cyc, output int rdy, output int nonidle);
    rdy = 0; nonidle = 0;
    for (int i = 0; i < cyc; i++) begin
      #1;
      if (s_ready === 1'b1) rdy++;
      if (txd !== 1'b1) nonidle++;
      @(negedge clk);
    end
  endtask

  task automatic check_frame(input int from, input bit under, input string req, output int h, output int d);
    int bad_at = -1;
    h = find_hs(from);
    d = 0;
    if (h < 0) begin
      check(1'b0, req, "message start seen", 0, 1);
      return;
    end
    for (int k = 0; k < n_ex; k++)
      if (lg_txd[h+1+k] != ex[k] && bad_at < 0) bad_at = k;
    check(bad_at < 0, req, "first wrong line bit index", bad_at, -1);
    d = h + 1 + n_ex;
    check(lg_done[d] && !lg_done[d-1] && lg_txd[d], under ? "R11" : "R5",
          "done pulse one cycle after final bit", int'(lg_done[d]), 1);
    check(lg_und[d] == under, under ? "R11" : "R5", "underrun flag", int'(lg_und[d]), int'(under));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check(txd === 1'b1, "R1", "txd in reset", int'(txd), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    check(txd === 1'b1, "R1", "txd disabled", int'(txd), 1);
    check(s_ready === 1'b0, "R1", "s_ready disabled", int'(s_ready), 0);
    check(msg_done === 1'b0, "R1", "msg_done disabled", int'(msg_done), 0);
    @(negedge clk);
  endtask

  task automatic t_basic();
    int e, h, d, ones;
    cts = 1'b1; sync_sel = 1'b0; crc_en = 1'b0; lsb_first = 1'b0;
    msg_b[0] = 8'hA5; msg_l[0] = 1'b0;
    msg_b[1] = 8'h3C; msg_l[1] = 1'b1;
    e = logn;
    tx_en = 1'b1;
    offer(0, 2);
    repeat (30) @(negedge clk);
    build(0, 2, 1'b0, 1'b0);
    check_frame(e, 1'b0, "R9 R10", h, d);
    ones = 0;
    for (int i = e; i <= h && h >= 0; i++) ones += int'(lg_txd[i]);
    check(h - e > GAP && ones == h - e + 1, "R2", "idle cycles before first bit", h - e, GAP + 1);
    #1;
    check(s_ready === 1'b1, "R13", "ready while armed without valid", int'(s_ready), 1);
    @(negedge clk);
  endtask

  task automatic t_sync_select();
    int rdy, nonidle, m, h, d;
    cts = 1'b0; rx_synced = 1'b1; sync_sel = 1'b0;
    msg_b[0] = 8'h96; msg_l[0] = 1'b1;
    s_data = msg_b[0]; s_last = 1'b1; s_valid = 1'b1;
    hold(25, rdy, nonidle);
    check(rdy == 0, "R3", "ready cycles with cts low", rdy, 0);
    check(nonidle == 0, "R3", "non-idle bits while blocked", nonidle, 0);
    m = logn;
    sync_sel = 1'b1;
    offer(0, 1);
    repeat (25) @(negedge clk);
    build(0, 1, 1'b0, 1'b0);
    check_frame(m, 1'b0, "R4", h, d);
    rx_synced = 1'b0; cts = 1'b1; s_valid = 1'b1;
    hold(20, rdy, nonidle);
    check(rdy == 0, "R4", "ready with receiver sync low", rdy, 0);
    s_valid = 1'b0; sync_sel = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_crc_b2b();
    int m1, m2, h1, d1, h2, d2, ones;
    cts = 1'b1; crc_en = 1'b1; lsb_first = 1'b1;
    msg_b[0] = 8'h31; msg_l[0] = 1'b0;
    msg_b[1] = 8'h32; msg_l[1] = 1'b0;
    msg_b[2] = 8'h33; msg_l[2] = 1'b1;
    msg_b[3] = 8'hC4; msg_l[3] = 1'b1;
    m1 = logn;
    offer(0, 3);
    m2 = logn;
    offer(3, 1);
    repeat (60) @(negedge clk);
    build(0, 3, 1'b1, 1'b1);
    check_frame(m1, 1'b0, "R9/R10", h1, d1);
    build(3, 1, 1'b1, 1'b1);
    check_frame(m2, 1'b0, "R10", h2, d2);
    ones = 0;
    for (int i = d1; i <= h2 && h2 >= 0; i++) ones += int'(lg_txd[i]);
    check(h2 + 1 - d1 >= GAP && ones == h2 + 1 - d1, "R6", "idle bits between messages", h2 + 1 - d1, GAP);
    crc_en = 1'b0; lsb_first = 1'b0;
  endtask

  task automatic t_resync();
    int m1, m2, h, d, rdy, nonidle;
    msg_b[0] = 8'h5A; msg_l[0] = 1'b1;
    msg_b[1] = 8'hE1; msg_l[1] = 1'b1;
    m1 = logn;
    offer(0, 1);
    cts = 1'b0;
    s_data = msg_b[1]; s_last = 1'b1; s_valid = 1'b1;
    hold(40, rdy, nonidle);
    check(rdy == 0, "R7", "ready after message with sync lost", rdy, 0);
    m2 = logn;
    cts = 1'b1;
    offer(1, 1);
    repeat (25) @(negedge clk);
    build(0, 1, 1'b0, 1'b0);
    check_frame(m1, 1'b0, "R7", h, d);
    build(1, 1, 1'b0, 1'b0);
    check_frame(m2, 1'b0, "R7", h, d);
  endtask

  task automatic t_sync_drop();
    int m, h, d;
    msg_b[0] = 8'h6B; msg_l[0] = 1'b0;
    msg_b[1] = 8'hD2; msg_l[1] = 1'b1;
    m = logn;
    fork
      offer(0, 2);
      begin repeat (4) @(negedge clk); cts = 1'b0; end
    join
    repeat (25) @(negedge clk);
    cts = 1'b1;
    build(0, 2, 1'b0, 1'b0);
    check_frame(m, 1'b0, "R8", h, d);
  endtask

  task automatic t_underrun();
    int m, h, d;
    msg_b[0] = 8'hF0; msg_l[0] = 1'b0;
    m = logn;
    offer(0, 1);
    repeat (30) @(negedge clk);
    build(0, 1, 1'b0, 1'b0);
    check_frame(m, 1'b1, "R11", h, d);
  endtask

  task automatic t_disable();
    int x, dn;
    msg_b[0] = 8'h00; msg_l[0] = 1'b0;
    offer(0, 1);
    repeat (3) @(negedge clk);
    x = logn;
    tx_en = 1'b0;
    @(negedge clk);
    #2;
    check(txd === 1'b1, "R12", "txd after disable", int'(txd), 1);
    check(s_ready === 1'b0, "R12", "s_ready after disable", int'(s_ready), 0);
    repeat (20) @(negedge clk);
    dn = 0;
    for (int i = x; i < logn; i++) dn += int'(lg_done[i]);
    check(dn == 0, "R12", "done pulses after disable", dn, 0);
    tx_en = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #750000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_sync_select();
    t_crc_b2b();
    t_resync();
    t_sync_drop();
    t_underrun();
    t_disable();
    summary();
    $finish;
  end
endmodule